// File: doc/BRIEF.md
# Nibble-Parallel CRC Engine with Run-Time Polynomial

This block keeps a 16-bit cyclic-redundancy state register and folds four data bits into it on every clock cycle in which the data-valid input is high. The generator polynomial is an ordinary input rather than a build-time constant. Software or a neighbouring block can change it between nibbles, so the next-state logic is a chain of generic shift-and-conditional-XOR stages rather than a fixed XOR matrix.

The four per-bit stages are unrolled into one combinational cone. The state register is the only element on the feedback path, so the design has no combinational loop. A clear input and the synchronous reset both load a parameterised seed. The output is the raw register value. Any final inversion or bit reversal is left to the consumer.

Top module: `crc_nibble_top`

## Requirements
- R1: While `rst` is high at a rising edge, `crc_out` shows the seed (default 0xFFFF) after that edge, whatever the values of `crc_clr` and `data_vld`.
- R2: `crc_clr` high at a rising edge loads the seed into `crc_out` after that edge, and it takes priority over `data_vld`.
- R3: With `rst`, `crc_clr` and `data_vld` all low at an edge, `crc_out` keeps its value, whatever `data_nib` and `poly_in` carry.
- R4: With `data_vld` high and `crc_clr` low, one edge absorbs `data_nib` in four steps, starting with bit 3 and ending with bit 0. Each step works as follows: feedback = state[15] XOR the data bit; the state shifts left by one with a 0 entering at bit 0; if feedback is 1 the state is XORed with `poly_in`. The result is visible after that same edge. For example, feeding the ASCII string "123456789" high nibble first with poly 0x1021 from the seed gives 0x29B1.
- R5: `poly_in` is sampled at each absorbing edge. A polynomial changed between two consecutive nibbles applies to the very next nibble.
- R6: With `poly_in` = 0, an absorbing edge shifts the state left by four with zeros entering, and the data has no effect.
- R7: `crc_out` is the state register itself, with no final XOR and no bit reflection applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads the seed |
| data_vld | input | 1 | Absorb `data_nib` at this edge |
| crc_clr | input | 1 | Load the seed at this edge, overrides `data_vld` |
| data_nib | input | 4 | Data nibble, bit 3 absorbed first |
| poly_in | input | 16 | Generator polynomial, may change every cycle |
| crc_out | output | 16 | Current state register value |

## Verification
The bench feeds the nine-character check string and compares the result with the known 0x29B1 value. A design with the wrong bit order or a misplaced feedback tap fails that check. It swaps the polynomial between consecutive nibbles, which would expose a design that latched the polynomial or lagged by a cycle. Clear is raised together with valid, and reset is raised together with both, so a design with the wrong priority absorbs a nibble instead of reseeding. Idle cycles carry changing data and polynomials to catch a design that updates without valid. A zero polynomial run separates pure shifting from any stray data injection.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;

    localparam int unsigned DEF_CRC_W = 16;
    localparam int unsigned DEF_NIB_W = 4;
    localparam logic [DEF_CRC_W-1:0] DEF_SEED = 16'hFFFF;

    // Register operation selected for one edge, in priority order
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_SEED   = 2'd1,
        OP_ABSORB = 2'd2
    } crc_op_e;

    // Decoded control for one edge
    typedef struct packed {
        crc_op_e op;
        logic    from_rst;
    } crc_ctl_t;

    // Priority decode: reset, then clear, then valid
    function automatic crc_ctl_t decode_ctl(logic rst, logic clr, logic vld);
        crc_ctl_t c;
        c.from_rst = rst;
        if (rst || clr) begin
            c.op = OP_SEED;
        end else if (vld) begin
            c.op = OP_ABSORB;
        end else begin
            c.op = OP_HOLD;
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_nib_bitstage.sv
module crc_nib_bitstage #(
    parameter int unsigned W = crc_nib_pkg::DEF_CRC_W
) (
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] poly,
    input  logic         dbit,
    output logic [W-1:0] s_out,
    output logic         fb
);
    logic [W-1:0] shifted;

    always_comb begin
        fb      = s_in[W-1] ^ dbit;
        shifted = {s_in[W-2:0], 1'b0};
        s_out   = fb ? (shifted ^ poly) : shifted;
    end
endmodule

// File: rtl/crc_nib_unroll.sv
module crc_nib_unroll #(
    parameter int unsigned W = crc_nib_pkg::DEF_CRC_W,
    parameter int unsigned N = crc_nib_pkg::DEF_NIB_W
) (
    input  logic [W-1:0] state,
    input  logic [W-1:0] poly,
    input  logic [N-1:0] nib,
    output logic [W-1:0] next
);
    logic [W-1:0] chain [0:N];
    logic [N-1:0] fb_vec;

    assign chain[0] = state;

    // Stage i handles data bit N-1-i, so the top bit goes first
    for (genvar i = 0; i < N; i++) begin : g_stage
        crc_nib_bitstage #(.W(W)) u_stage (
            .s_in  (chain[i]),
            .poly  (poly),
            .dbit  (nib[N-1-i]),
            .s_out (chain[i+1]),
            .fb    (fb_vec[N-1-i])
        );
    end

    assign next = chain[N];

    // A zero polynomial leaves only the shift
    always_comb begin
        if (poly == '0) begin
            AST_ZERO_POLY_SHIFT: assert (next == (state << N)); // R6
        end
    end
endmodule

// File: rtl/crc_nib_reg.sv
module crc_nib_reg #(
    parameter int unsigned            W    = crc_nib_pkg::DEF_CRC_W,
    parameter logic [W-1:0]           SEED = crc_nib_pkg::DEF_SEED
) (
    input  logic                   clk,
    input  logic                   rst,
    input  crc_nib_pkg::crc_ctl_t  ctl,
    input  logic [W-1:0]           next,
    output logic [W-1:0]           state
);
    import crc_nib_pkg::*;

    always_ff @(posedge clk) begin
        case (ctl.op)
            OP_SEED:   state <= SEED;
            OP_ABSORB: state <= next;
            default:   state <= state;
        endcase
    end

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_q) begin
            AST_RST_SEED: assert (state == SEED); // R1
        end
    end

    AST_CLR_SEED: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == OP_SEED) |=> (state == SEED)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == OP_HOLD) |=> $stable(state)); // R3

    AST_ABSORB_NEXT: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == OP_ABSORB) |=> (state == $past(next))); // R4
endmodule

// File: rtl/crc_nibble_top.sv
module crc_nibble_top #(
    parameter int unsigned             CRC_W = crc_nib_pkg::DEF_CRC_W,
    parameter int unsigned             NIB_W = crc_nib_pkg::DEF_NIB_W,
    parameter logic [CRC_W-1:0]        SEED  = crc_nib_pkg::DEF_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             data_vld,
    input  logic             crc_clr,
    input  logic [NIB_W-1:0] data_nib,
    input  logic [CRC_W-1:0] poly_in,
    output logic [CRC_W-1:0] crc_out
);
    import crc_nib_pkg::*;

    crc_ctl_t         ctl;
    logic [CRC_W-1:0] state;
    logic [CRC_W-1:0] next;

    assign ctl = decode_ctl(rst, crc_clr, data_vld);

    crc_nib_unroll #(.W(CRC_W), .N(NIB_W)) u_unroll (
        .state (state),
        .poly  (poly_in),
        .nib   (data_nib),
        .next  (next)
    );

    crc_nib_reg #(.W(CRC_W), .SEED(SEED)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .next  (next),
        .state (state)
    );

    // Output is the register itself, no post-processing
    assign crc_out = state;

    AST_ZERO_POLY_PORT: assert property (@(posedge clk) disable iff (rst)
        (data_vld && !crc_clr && poly_in == '0) |=>
        (crc_out == {$past(crc_out[CRC_W-NIB_W-1:0]), {NIB_W{1'b0}}})); // R6

    AST_OUT_SEED_AFTER_CLR: assert property (@(posedge clk) disable iff (rst)
        crc_clr |=> (crc_out == SEED)); // R7
endmodule

// File: tb/test_crc_nibble_top.sv
`timescale 1ns/1ps
module test_crc_nibble_top;
    logic        clk = 1'b1;
    logic        rst, data_vld, crc_clr;
    logic [3:0]  data_nib;
    logic [15:0] poly_in;
    logic [15:0] crc_out;

    localparam logic [15:0] SEED = 16'hFFFF;

    always #2.5 clk = ~clk;

    crc_nibble_top i_crc_nibble_top (
        .clk(clk), .rst(rst), .data_vld(data_vld), .crc_clr(crc_clr),
        .data_nib(data_nib), .poly_in(poly_in), .crc_out(crc_out)
    );

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] model;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    function automatic logic [15:0] ref_absorb(logic [15:0] s, logic [15:0] p, logic [3:0] d);
        for (int b = 3; b >= 0; b--) begin
            logic f;
            f = s[15] ^ d[b];
            s = {s[14:0], 1'b0};
            if (f) s = s ^ p;
        end
        return s;
    endfunction

    // Driver: one call is one clock cycle and one expected item
    task automatic drive(logic r, logic c, logic v, logic [3:0] d, logic [15:0] p, string tag);
        @(negedge clk);
        rst = r; crc_clr = c; data_vld = v; data_nib = d; poly_in = p;
        if (r || c)  model = SEED;
        else if (v)  model = ref_absorb(model, p, d);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic expect_literal(logic [15:0] want, string tag);
        n_run++;
        if (model !== want) begin
            n_fail++;
            $display("FAIL %s: model 0x%04h expected 0x%04h", tag, model, want);
        end
    endtask

    // Monitor: compare one item per edge, just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                if (crc_out !== e) begin
                    n_fail++;
                    $display("FAIL %s: crc_out 0x%04h expected 0x%04h", t, crc_out, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d expected 0 pending", exp_q.size());
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        string msg;
        rst = 1; crc_clr = 0; data_vld = 0; data_nib = 0; poly_in = 0;
        model = SEED;

        // R1 reset, also with clear and valid raised
        drive(1, 0, 0, 4'h0, 16'h0000, "R1 reset");
        drive(1, 1, 1, 4'hA, 16'h1021, "R1 reset priority");
        drive(1, 0, 1, 4'h5, 16'h1021, "R1 reset over valid");

        // R4 check string, high nibble first
        msg = "123456789";
        for (int i = 0; i < msg.len(); i++) begin
            logic [7:0] ch;
            ch = msg[i];
            drive(0, 0, 1, ch[7:4], 16'h1021, "R4 check string");
            drive(0, 0, 1, ch[3:0], 16'h1021, "R4 check string");
        end
        expect_literal(16'h29B1, "R4 known check value");

        // R3 idle with wiggling data and polynomial
        for (int i = 0; i < 6; i++)
            drive(0, 0, 0, 4'(i * 3 + 1), 16'(16'h8005 + i * 16'h1111), "R3 idle hold");

        // R2 clear with valid, then R7 raw seed on output
        drive(0, 1, 1, 4'hF, 16'h1021, "R2 clear over valid");
        expect_literal(16'hFFFF, "R7 raw seed");
        drive(0, 0, 0, 4'h3, 16'h1021, "R7 no final xor");

        // R4 varied nibbles and polynomials
        for (int i = 0; i < 16; i++)
            drive(0, 0, 1, 4'(i), 16'h8005, "R4 nibble sweep");
        drive(0, 1, 0, 4'h0, 16'h0000, "R2 clear");
        drive(0, 0, 1, 4'h0, 16'h1021, "R4 zero nibble");
        drive(0, 0, 1, 4'hF, 16'h1021, "R4 ones nibble");

        // R5 polynomial changed every nibble
        for (int i = 0; i < 12; i++)
            drive(0, 0, 1, 4'(i ^ 5), (i % 2 == 0) ? 16'h1021 : 16'hC867, "R5 poly swap");

        // R6 zero polynomial: shift only, data ignored
        drive(0, 1, 0, 4'h0, 16'h0000, "R2 clear");
        drive(0, 0, 1, 4'hA, 16'h0000, "R6 zero poly");
        expect_literal(16'hFFF0, "R6 shift literal");
        drive(0, 0, 1, 4'h5, 16'h0000, "R6 zero poly");
        drive(0, 0, 1, 4'hF, 16'h0000, "R6 zero poly");
        expect_literal(16'hF000, "R6 shift literal");

        // R3 hold across mixed idle, then resume
        drive(0, 0, 0, 4'h9, 16'hFFFF, "R3 idle hold");
        drive(0, 0, 1, 4'h9, 16'hA001, "R4 resume");
        drive(0, 0, 0, 4'h2, 16'h0001, "R3 idle hold");

        // R1 reset mid-stream
        drive(1, 0, 1, 4'h7, 16'h1021, "R1 reset mid stream");
        drive(0, 0, 0, 4'h0, 16'h1021, "R1 after reset");

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 scoreboard drain: pending %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule